// File: doc/BRIEF.md
# Cascadable Latched Serial-to-Parallel Output Driver

This block takes a serial bit stream and a shift clock from a host controller and drives a wide bank of parallel output lines. The parallel lines suit loads such as LED segments. Each rising clock edge moves one new bit into a 20-stage shift register. An output latch sits between the register and the parallel lines, so a frame can be shifted in while the loads keep showing the previous frame. The host needs only four signals: data, clock, an active-low strobe and an active-low clear.

When the strobe is low, the latch is transparent. The parallel lines then show the register and follow it as it keeps shifting. When the strobe returns high, the last value is frozen on the lines. The clear acts on the latch only and needs no clock edge. While it is low, every parallel line is held low whatever the strobe does. It never disturbs the register contents.

The last register stage drives a serial output. That output does not depend on the strobe or the clear. Tying it to the data input of the next unit chains units into one longer register that shares the clock, strobe and clear. The register has no reset, so the host shifts in a complete frame before it first opens the latch.

Top module: `cascade_sipo_driver`

## Requirements
- R1: On every rising edge of clk_i, data_i enters stage 1 and every other stage takes the value of the stage before it, whatever the levels of stb_ni and clr_ni. After 20 edges that shift bits b19 first down to b0 last, with the latch then transparent, par_o equals {b19..b0}.
- R2: par_o[0] shows stage 1, which holds the most recent bit, and par_o[19] shows stage 20. A single 1 followed by 19 zeros reads as par_o = 20'h80000.
- R3: While stb_ni is high and clr_ni is high, par_o keeps its value across clock edges.
- R4: While stb_ni is low and clr_ni is high, par_o equals the shift register and follows it after every clock edge (transparent latch).
- R5: While clr_ni is low, par_o is all zeros at once, without a clock edge, whatever the level of stb_ni.
- R6: The clear leaves the shift register unchanged and it keeps shifting. After clr_ni rises with stb_ni high, par_o stays zero until stb_ni next goes low. It then shows the register, including the bits shifted during the clear.
- R7: so_o is stage 20 of the register whatever the levels of stb_ni and clr_ni. Two units chained so_o to data_i act as one 40-stage register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shift clock, rising edge active |
| data_i | input | 1 | Serial data into stage 1 |
| stb_ni | input | 1 | Active-low latch enable (transparent while low) |
| clr_ni | input | 1 | Active-low asynchronous clear of the output latch |
| par_o | output | 20 | Parallel latched outputs, bit 0 = stage 1 |
| so_o | output | 1 | Serial cascade output, stage 20 |

## Verification
The register and so_o change one clock edge after data_i is presented. The bench changes inputs on falling edges and checks 1 ns after the next rising edge. par_o and the clear have no clock delay: strobe and clear changes appear on par_o at once, so the bench also checks 1 ns after each falling-edge drive. A bench model of two chained units computes the expected outputs at both of these sample points.

// File: rtl/sipo_driver_pkg.sv
package sipo_driver_pkg;
  localparam int unsigned SIPO_WIDTH = 20;
endpackage

// File: rtl/sipo_shift_reg.sv
module sipo_shift_reg #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             clk_i,
  input  logic             data_i,
  output logic [WIDTH-1:0] q_o,
  output logic             so_o
);
  // no reset by intent: clear only affects the latch
  logic [WIDTH-1:0] sr_q;

  always_ff @(posedge clk_i) begin
    sr_q <= {sr_q[WIDTH-2:0], data_i};
  end

  assign q_o  = sr_q;
  assign so_o = sr_q[WIDTH-1];
endmodule

// File: rtl/sipo_latch_bank.sv
module sipo_latch_bank #(
  parameter int unsigned WIDTH = 20
) (
  input  logic             stb_ni,
  input  logic             clr_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);
  for (genvar i = 0; i < WIDTH; i++) begin : g_bit
    logic bit_q;
    always_latch begin
      if (!clr_ni)      bit_q <= 1'b0;
      else if (!stb_ni) bit_q <= d_i[i];
    end
    assign q_o[i] = bit_q;
  end
endmodule

// File: rtl/cascade_sipo_driver.sv
module cascade_sipo_driver
  import sipo_driver_pkg::*;
#(
  parameter int unsigned WIDTH = SIPO_WIDTH
) (
  input  logic             clk_i,
  input  logic             data_i,
  input  logic             stb_ni,
  input  logic             clr_ni,
  output logic [WIDTH-1:0] par_o,
  output logic             so_o
);
  logic [WIDTH-1:0] shift_q;

  sipo_shift_reg #(.WIDTH(WIDTH)) u_shift (
    .clk_i  (clk_i),
    .data_i (data_i),
    .q_o    (shift_q),
    .so_o   (so_o)
  );

  sipo_latch_bank #(.WIDTH(WIDTH)) u_latch (
    .stb_ni (stb_ni),
    .clr_ni (clr_ni),
    .d_i    (shift_q),
    .q_o    (par_o)
  );
endmodule

// File: rtl/sipo_driver_checker.sv
module sipo_driver_checker #(
  parameter int unsigned WIDTH = 20
) (
  input logic             clk_i,
  input logic             data_i,
  input logic             stb_ni,
  input logic             clr_ni,
  input logic [WIDTH-1:0] par_o,
  input logic             so_o,
  input logic [WIDTH-1:0] sr_i
);
  logic [1:0] age_q = 2'd0;
  always_ff @(posedge clk_i) if (age_q != 2'd3) age_q <= age_q + 2'd1;

  AST_SHIFT_IN: assert property (@(posedge clk_i) disable iff (age_q == 2'd0)
    sr_i[0] == $past(data_i)); // R1
  AST_HOLD: assert property (@(posedge clk_i) disable iff (age_q == 2'd0 || !clr_ni)
    (stb_ni && $past(stb_ni) && $past(clr_ni)) |-> $stable(par_o)); // R3
  AST_TRACK: assert property (@(posedge clk_i) disable iff (age_q == 2'd0)
    (!stb_ni && clr_ni) |-> (par_o == sr_i)); // R4
  AST_CLR_ZERO: assert property (@(posedge clk_i) disable iff (age_q == 2'd0)
    !clr_ni |-> (par_o == '0)); // R5
  AST_CASCADE_OUT: assert property (@(posedge clk_i) disable iff (age_q < 2'd2)
    so_o == $past(sr_i[WIDTH-2])); // R7
endmodule

bind cascade_sipo_driver sipo_driver_checker #(.WIDTH(WIDTH)) u_chk (
  .clk_i  (clk_i),
  .data_i (data_i),
  .stb_ni (stb_ni),
  .clr_ni (clr_ni),
  .par_o  (par_o),
  .so_o   (so_o),
  .sr_i   (shift_q)
);

// File: tb/cascade_sipo_driver_tb_top.sv
`timescale 1ns/1ps
module cascade_sipo_driver_tb_top;
  localparam int W = 20;
  localparam time CYC = 20ns;

  logic clk = 1'b0;
  logic data = 1'b0, stb = 1'b1, clr = 1'b0;
  logic [W-1:0] par0, par1;
  logic so0, so1;

  always #(CYC/2) clk = ~clk;

  cascade_sipo_driver dut_i (
    .clk_i(clk), .data_i(data), .stb_ni(stb), .clr_ni(clr), .par_o(par0), .so_o(so0));
  cascade_sipo_driver dut2_i (
    .clk_i(clk), .data_i(so0), .stb_ni(stb), .clr_ni(clr), .par_o(par1), .so_o(so1));

  logic [W-1:0] m0 = '0, m1 = '0, l0 = '0, l1 = '0;
  int n_vec = 0, n_fail = 0;
  bit chk_so = 1'b0, done = 1'b0;

  function automatic string auto_tag();
    if (!clr) return "R5";
    if (!stb) return "R4";
    return "R3";
  endfunction

  task automatic upd_latch();
    if (!clr) begin l0 = '0; l1 = '0; end
    else if (!stb) begin l0 = m0; l1 = m1; end
  endtask

  task automatic cmp(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s t=%0t actual=%h expected=%h", tag, $time, act, exp);
    end
  endtask

  task automatic check_all(input string tag);
    string t = (tag == "") ? auto_tag() : tag;
    cmp(t, par0, l0);
    cmp({t, "_cascade"}, par1, l1);
    if (chk_so) begin
      cmp("R7", W'(so0), W'(m0[W-1]));
      cmp("R7", W'(so1), W'(m1[W-1]));
    end
  endtask

  task automatic step(input logic d, input logic s, input logic c, input string tag);
    @(negedge clk);
    data = d; stb = s; clr = c;
    #1; upd_latch(); check_all(tag);
    @(posedge clk);
    m1 = {m1[W-2:0], m0[W-1]};
    m0 = {m0[W-2:0], d};
    #1; upd_latch(); check_all(tag);
  endtask

  initial begin
    void'($urandom(32'd4321));
    #1; check_all("R5");
    for (int i = 0; i < 2*W; i++) step(1'($urandom), 1'b1, 1'b0, "R5");
    chk_so = 1'b1;
    // release clear with strobe high: latch stays zero
    for (int i = 0; i < 5; i++) step(1'($urandom), 1'b1, 1'b1, "R6");
    for (int i = 0; i < 30; i++) step(1'($urandom), 1'b1, 1'b1, "R3");
    step(1'b1, 1'b0, 1'b1, "R4");
    for (int i = 0; i < 10; i++) step(1'($urandom), 1'b0, 1'b1, "R4");
    // R2: single marker bit reaches the far end after 20 edges
    step(1'b1, 1'b1, 1'b1, "R2");
    for (int i = 0; i < W-2; i++) step(1'b0, 1'b1, 1'b1, "R2");
    step(1'b0, 1'b0, 1'b1, "R2");
    cmp("R2", par0, 20'h80000);
    // R1: known frame, first bit ends at par_o[19]
    for (int i = W-1; i >= 1; i--) step(1'(20'hA5C3E >> i), 1'b1, 1'b1, "R1");
    step(1'(20'hA5C3E), 1'b0, 1'b1, "R1");
    cmp("R1", par0, 20'hA5C3E);
    // R5 overriding strobe, R6 register keeps shifting under clear
    for (int i = 0; i < 7; i++) step(1'($urandom), 1'b0, 1'b0, "R5");
    for (int i = 0; i < 3; i++) step(1'($urandom), 1'b1, 1'b1, "R6");
    step(1'b1, 1'b0, 1'b1, "R6");
    for (int i = 0; i < 400; i++)
      step(1'($urandom), ($urandom % 4) != 0, ($urandom % 8) != 0, "");
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end

  initial begin
    #(CYC*100000);
    if (!done) begin
      done = 1'b1;
      n_fail++;
      $display("FAIL watchdog expired at t=%0t", $time);
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_fail);
      $finish;
    end
  end
endmodule